// File: doc/BRIEF.md
# Signed Adder/Subtractor with Double-Width Sign-Extended Result

This block adds or subtracts two signed two's-complement operands of parameterised width N and returns the result as a value of 2N bits. The value is split across two N-bit buses. The low bus carries the N-bit sum or difference. Every bit of the high bus carries one extension bit. A one-bit mode input selects the operation. When subtraction is selected, each bit of the second operand is inverted and the carry-in is forced to 1, so the block computes A + ~B + 1 on the same carry chain that it uses for addition.

The extension bit is taken from the signed result and never from the raw carry-out. A carry-out of 1 is common in subtraction even when the difference is small and positive. When the signed N-bit range is not exceeded, the extension bit is the most significant bit (MSB) of the sum. When the range is exceeded, an overflow flag rises and the extension bit is the inverted sum MSB. In both cases the concatenation {high, low} equals the exact mathematical result. The block is purely combinational. It suits datapaths that feed a bus split into high and low halves.

The structure has three stages. An operand conditioner applies the mode to the second operand and to the carry-in. A ripple carry chain exposes the carry into its top bit as well as its carry-out. A sign-fill stage derives the overflow flag and the extension bit from those two carries.

Top module: `addsub_sext`

The block has no state machine and therefore no states or transitions. The output is a combinational function of the present inputs.

## Requirements
- R1: With mode_sub = 0 (add), res_lo equals (op_a + op_b) mod 2^N.
- R2: With mode_sub = 1 (subtract), res_lo equals (op_a - op_b) mod 2^N, formed as op_a + ~op_b + 1.
- R3: When ovf_flag is 0, every bit of res_hi equals res_lo[N-1].
- R4: ovf_flag is 1 exactly when the exact signed result lies outside the range -2^(N-1) to 2^(N-1)-1.
- R5: When ovf_flag is 1, every bit of res_hi equals the inverse of res_lo[N-1], so {res_hi, res_lo} still equals the exact result.
- R6: res_hi is always either all zeros or all ones.
- R7: The carry-out of the chain has no bearing on res_hi. Two examples at N=8: 3 - 2 yields res_hi = 0 and res_lo = 1, although the carry-out is 1. The sum -3 + -3 yields res_hi = all ones and res_lo = 0xFA.
- R8: For every input combination, {res_hi, res_lo}, read as a 2N-bit two's-complement number, equals op_a + op_b or op_a - op_b exactly. The outputs follow the inputs combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First signed operand |
| op_b | input | N | Second signed operand |
| mode_sub | input | 1 | 0 selects add, 1 selects subtract |
| res_lo | output | N | Low half: N-bit sum or difference |
| res_hi | output | N | High half: replicated extension bit |
| ovf_flag | output | 1 | Signed overflow of the N-bit result |

## Verification
The embedded checks are immediate assertions on settled combinational values. They assume that op_a, op_b and mode_sub change only at whole time steps and never carry X or Z values.

The bench drives all three inputs together from a single task, one clock phase before it samples. It also loads every input with a defined value before the first sample.

A 4-bit instance is swept over all 512 operand and mode combinations. An 8-bit instance receives seeded random vectors mixed with directed range-edge cases.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Operation selected by the mode input
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/operand_cond.sv
module operand_cond
    import addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] b_in,
    input  op_e          op,
    output logic [N-1:0] b_eff,
    output logic         cin
);

    logic inv;

    assign inv = (op == OP_SUB);
    assign cin = inv;

    // One XOR per operand bit: invert the operand when subtracting
    for (genvar i = 0; i < N; i++) begin : g_xor
        assign b_eff[i] = b_in[i] ^ inv;
    end

endmodule

// File: rtl/carry_chain.sv
module carry_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         c_top_in,
    output logic         c_out
);

    logic [N:0] c;

    assign c[0] = cin;

    // One full adder per bit, chained through the carries
    for (genvar i = 0; i < N; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    assign c_top_in = c[N-1];
    assign c_out    = c[N];

    // The bitwise chain must agree with whole-word arithmetic
    always_comb begin
        p_chain_sum_r1: assert ({c_out, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
            else $error("carry chain disagrees with word sum");
    end

endmodule

// File: rtl/sign_fill.sv
module sign_fill (
    input  logic a_msb,
    input  logic b_msb,
    input  logic sum_msb,
    input  logic c_top_in,
    input  logic c_out,
    output logic ovf,
    output logic ext
);

    logic flip;

    // The carries into and out of the top bit disagree on overflow
    assign ovf  = c_top_in ^ c_out;
    assign flip = ovf;
    // On overflow the true sign is the inverse of the sum MSB
    assign ext  = sum_msb ^ flip;

    // Check R4 against the operand-sign view of overflow
    always_comb begin
        p_ovf_signs_r4: assert (ovf == ((a_msb == b_msb) && (sum_msb != a_msb)))
            else $error("overflow flag disagrees with operand signs");
    end

endmodule

// File: rtl/addsub_sext.sv
module addsub_sext
    import addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         mode_sub,
    output logic [N-1:0] res_lo,
    output logic [N-1:0] res_hi,
    output logic         ovf_flag
);

    localparam int MSB = N - 1;

    op_e          op;
    logic [N-1:0] b_eff;
    logic         cin;
    logic [N-1:0] sum;
    logic         c_top_in;
    logic         c_out;
    logic         ext;

    assign op = op_e'(mode_sub);

    operand_cond #(.N(N)) u_cond (
        .b_in  (op_b),
        .op    (op),
        .b_eff (b_eff),
        .cin   (cin)
    );

    carry_chain #(.N(N)) u_chain (
        .a        (op_a),
        .b        (b_eff),
        .cin      (cin),
        .sum      (sum),
        .c_top_in (c_top_in),
        .c_out    (c_out)
    );

    sign_fill u_fill (
        .a_msb    (op_a[MSB]),
        .b_msb    (b_eff[MSB]),
        .sum_msb  (sum[MSB]),
        .c_top_in (c_top_in),
        .c_out    (c_out),
        .ovf      (ovf_flag),
        .ext      (ext)
    );

    assign res_lo = sum;
    assign res_hi = {N{ext}};

    // Output relations between the chain and the sign-fill stage
    always_comb begin
        p_hi_uniform_r6: assert ((res_hi == '0) || (res_hi == '1))
            else $error("high bus is not uniform");
        p_no_overflow_r3: assert (ovf_flag || (res_hi[0] == res_lo[MSB]))
            else $error("extension differs from sum MSB without overflow");
        p_overflow_fix_r5: assert (!ovf_flag || (res_hi[0] != res_lo[MSB]))
            else $error("extension not corrected on overflow");
    end

endmodule

// File: tb/addsub_sext_test.sv
module addsub_sext_test;

    localparam int W  = 8;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0]  a8, b8, lo8, hi8;
    logic          m8, ov8;
    logic [WS-1:0] a4, b4, lo4, hi4;
    logic          m4, ov4;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    addsub_sext #(.N(W)) uut (
        .op_a(a8), .op_b(b8), .mode_sub(m8),
        .res_lo(lo8), .res_hi(hi8), .ovf_flag(ov8)
    );

    addsub_sext #(.N(WS)) uut_small (
        .op_a(a4), .op_b(b4), .mode_sub(m4),
        .res_lo(lo4), .res_hi(hi4), .ovf_flag(ov4)
    );

    // Interpret an n-bit pattern as a signed integer
    function automatic longint to_signed(int n, longint v);
        return (v >= (longint'(1) << (n - 1))) ? v - (longint'(1) << n) : v;
    endfunction

    // Exact signed result of the selected operation
    function automatic longint exact(int n, longint a, longint b, bit sub);
        return sub ? to_signed(n, a) - to_signed(n, b) : to_signed(n, a) + to_signed(n, b);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare all outputs of one vector against the requirements
    task automatic judge(int n, longint a, longint b, bit sub,
                         longint lo, longint hi, bit ov);
        longint e    = exact(n, a, b, sub);
        longint mask = (longint'(1) << n) - 1;
        longint full = (longint'(1) << (2 * n)) - 1;
        longint mx   = (longint'(1) << (n - 1)) - 1;
        longint mn   = -(longint'(1) << (n - 1));
        bit     eov  = (e > mx) || (e < mn);
        longint ehi  = (e < 0) ? mask : 0;
        check(sub ? "R2 low bus" : "R1 low bus", lo, e & mask);
        check("R4 overflow flag", longint'(ov), longint'(eov));
        if (eov) check("R5 corrected extension", hi, ehi);
        else     check("R3 plain extension", hi, ehi);
        check("R6 uniform high bus", longint'((hi == 0) || (hi == mask)), 1);
        check("R8 full value", ((hi << n) | lo) & full, e & full);
    endtask

    // Drive on the rising edge, sample on the falling edge
    task automatic run8(logic [W-1:0] a, logic [W-1:0] b, bit sub);
        @(posedge clk);
        a8 <= a; b8 <= b; m8 <= sub;
        @(negedge clk);
        judge(W, a, b, sub, lo8, hi8, ov8);
    endtask

    task automatic run4(logic [WS-1:0] a, logic [WS-1:0] b, bit sub);
        @(posedge clk);
        a4 <= a; b4 <= b; m4 <= sub;
        @(negedge clk);
        judge(WS, a, b, sub, lo4, hi4, ov4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1F2E3D4C;
        a8 = '0; b8 = '0; m8 = 1'b0;
        a4 = '0; b4 = '0; m4 = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state: zero inputs give an all-zero result (R1)
        check("R1 idle low", longint'(lo8), 0);
        check("R3 idle high", longint'(hi8), 0);
        check("R4 idle flag", longint'(ov8), 0);

        // R7: the carry-out is 1 but the extension must be zero
        run8(8'd3, 8'd2, 1'b1);
        check("R7 3-2 high", longint'(hi8), 0);
        check("R7 3-2 low", longint'(lo8), 1);
        run8(8'hFD, 8'hFD, 1'b0);
        check("R7 -3+-3 high", longint'(hi8), 'hFF);
        check("R7 -3+-3 low", longint'(lo8), 'hFA);

        // Range edges that overflow or just fit
        run8(8'h7F, 8'h01, 1'b0);
        run8(8'h80, 8'h01, 1'b1);
        run8(8'h80, 8'h80, 1'b1);
        run8(8'h00, 8'h80, 1'b1);
        run8(8'h80, 8'h80, 1'b0);
        run8(8'h7F, 8'h7F, 1'b0);
        run8(8'hFF, 8'h7F, 1'b1);

        // Exhaustive sweep on the narrow instance
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(WS'(a), WS'(b), m[0]);

        // Seeded random vectors on the default width
        void'($urandom(seed));
        for (int k = 0; k < 2000; k++)
            run8(W'($urandom), W'($urandom), 1'($urandom));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule